// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a bank of level-sensitive interrupt sources, lets software enable or disable each source separately, and collapses each group of eight sources into one combined interrupt line. With the defaults there are 32 sources in four groups. Group n holds source bits 8n through 8n+7, so each group occupies one byte lane of the register word.

Software programs the enables through a 32-bit register port with address, write strobe, write data, read strobe and read data. There are two write-one-to-update registers. Ones written to the first register turn enables on, and ones written to the second turn them off. Zero bits leave the existing enables as they are, so no read-modify-write sequence is needed. A third register reports which sources are both asserted and enabled.

Pending state is not stored. A source is pending only while its line is high. Each group output is registered and follows its inputs and enables with one clock of delay.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and the status register reads 0 even when all source lines are high.
- R2: A write to byte offset 0x0 sets the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable.
- R3: A write to byte offset 0x4 clears the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable. If a set and a clear of the same bit take effect in the same cycle, the clear wins.
- R4: Reading byte offset 0xC returns, in bit i, the AND of source line i and enable i. The value follows the live line level, and a source that drops low reads 0 at once.
- R5: Group output n equals the OR of status bits 8n to 8n+7 as they stood one clock edge earlier.
- R6: Writing 0xFF shifted left by 8n to offset 0x4 disables all of group n in one write. Group output n falls, and the other groups keep their enables and outputs.
- R7: Reading offset 0x0 or offset 0x4 returns the current enable vector.
- R8: Reads of any other offset return 0. Writes to offset 0xC or to any other offset do not change the enables.
- R9: While the read strobe is low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BUS_W (32) | Read data, combinational while bus_rd is high |
| irq_src | input | SRC_W (32) | Level-sensitive interrupt sources |
| irq_grp | output | NUM_GROUPS (4) | Registered combined interrupt, one per group |

## Verification
The hardest case to show from the ports is masking of a source that is high but disabled. Its raw level must never appear in status or on its group line. The stimulus therefore holds every source line high while enables are built up and torn down bit by bit and group by group. Each status read and each group output must then match the enable pattern exactly. A second pass drops single lines while they are still enabled, which shows that no pending state is held. Writes to the status offset and to unused offsets come between reads of the enable vector, so any corruption they cause is visible.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      IRQC_SEL_NONE = 2'd0,
      IRQC_SEL_SET  = 2'd1,
      IRQC_SEL_CLR  = 2'd2,
      IRQC_SEL_STAT = 2'd3
   } irqc_sel_e;
endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec #(
   parameter int ADDR_W   = 4,
   parameter int OFS_SET  = 0,
   parameter int OFS_CLR  = 4,
   parameter int OFS_STAT = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output irqc_pkg::irqc_sel_e sel
);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   always_comb begin
      if (addr == A_SET)       sel = irqc_pkg::IRQC_SEL_SET;
      else if (addr == A_CLR)  sel = irqc_pkg::IRQC_SEL_CLR;
      else if (addr == A_STAT) sel = irqc_pkg::IRQC_SEL_STAT;
      else                     sel = irqc_pkg::IRQC_SEL_NONE;
   end
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
   parameter int SRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] set_mask,
   input  logic [SRC_W-1:0] clr_mask,
   output logic [SRC_W-1:0] en
);
   logic [SRC_W-1:0] en_q;
   logic [SRC_W-1:0] en_d;

   // clear has priority over set on the same bit
   always_comb en_d = (en_q | set_mask) & ~clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   assign en = en_q;
endmodule

// File: rtl/irqc_group_or.sv
module irqc_group_or #(
   parameter int NUM_GROUPS  = 4,
   parameter int GROUP_WIDTH = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] pend,
   output logic [NUM_GROUPS-1:0]             grp_irq
);
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= 1'b0;
         else        line_q <= |pend[g*GROUP_WIDTH +: GROUP_WIDTH];
      end
      assign grp_irq[g] = line_q;
   end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
   parameter int NUM_GROUPS  = 4,
   parameter int GROUP_WIDTH = 8,
   parameter int BUS_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int OFS_SET     = 0,
   parameter int OFS_CLR     = 4,
   parameter int OFS_STAT    = 12,
   localparam int SRC_W      = NUM_GROUPS * GROUP_WIDTH
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [BUS_W-1:0]      bus_wdata,
   input  logic                  bus_rd,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic [SRC_W-1:0]      irq_src,
   output logic [NUM_GROUPS-1:0] irq_grp
);
   import irqc_pkg::*;

   // elaboration-time parameter checks
   if (SRC_W != BUS_W) begin : g_bad_width
      $error("source count must equal the bus width");
   end
   if (NUM_GROUPS < 1 || GROUP_WIDTH < 1) begin : g_bad_groups
      $error("group count and group width must be positive");
   end
   if (OFS_SET == OFS_CLR || OFS_SET == OFS_STAT || OFS_CLR == OFS_STAT) begin : g_bad_ofs
      $error("register offsets must be distinct");
   end
   if ((OFS_SET % 4) != 0 || (OFS_CLR % 4) != 0 || (OFS_STAT % 4) != 0) begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (OFS_STAT >= (1 << ADDR_W) || OFS_CLR >= (1 << ADDR_W) || OFS_SET >= (1 << ADDR_W)) begin : g_bad_range
      $error("register offsets must fit the address width");
   end

   irqc_sel_e        sel;
   logic [SRC_W-1:0] set_mask;
   logic [SRC_W-1:0] clr_mask;
   logic [SRC_W-1:0] en_q;
   logic [SRC_W-1:0] pend;

   irqc_regdec #(
      .ADDR_W  (ADDR_W),
      .OFS_SET (OFS_SET),
      .OFS_CLR (OFS_CLR),
      .OFS_STAT(OFS_STAT)
   ) u_dec (
      .addr(bus_addr),
      .sel (sel)
   );

   assign set_mask = (bus_wr && sel == IRQC_SEL_SET) ? bus_wdata : '0;
   assign clr_mask = (bus_wr && sel == IRQC_SEL_CLR) ? bus_wdata : '0;

   irqc_enable_bank #(.SRC_W(SRC_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mask(set_mask),
      .clr_mask(clr_mask),
      .en      (en_q)
   );

   assign pend = irq_src & en_q;

   irqc_group_or #(
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_WIDTH(GROUP_WIDTH)
   ) u_or (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend   (pend),
      .grp_irq(irq_grp)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            IRQC_SEL_SET,
            IRQC_SEL_CLR:  bus_rdata = en_q;
            IRQC_SEL_STAT: bus_rdata = pend;
            default:       bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int NUM_GROUPS  = 4,
   parameter int GROUP_WIDTH = 8,
   parameter int BUS_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int OFS_SET     = 0,
   parameter int OFS_CLR     = 4,
   parameter int OFS_STAT    = 12,
   localparam int SRC_W      = NUM_GROUPS * GROUP_WIDTH
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_wr,
   input logic [BUS_W-1:0]      bus_wdata,
   input logic                  bus_rd,
   input logic [BUS_W-1:0]      bus_rdata,
   input logic [SRC_W-1:0]      irq_src,
   input logic [NUM_GROUPS-1:0] irq_grp,
   input logic [SRC_W-1:0]      en_q
);
   logic hit_set, hit_clr, hit_stat, hit_none;
   logic [NUM_GROUPS-1:0] grp_now;

   assign hit_set  = bus_addr == ADDR_W'(OFS_SET);
   assign hit_clr  = bus_addr == ADDR_W'(OFS_CLR);
   assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
   assign hit_none = !hit_set && !hit_clr;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_now[g] = |(irq_src[g*GROUP_WIDTH +: GROUP_WIDTH] & en_q[g*GROUP_WIDTH +: GROUP_WIDTH]);
   end

   // R2
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_set) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));
   // R2
   set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_set) |=> ((en_q & ~$past(bus_wdata)) == ($past(en_q) & ~$past(bus_wdata))));
   // R3
   clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_clr) |=> ((en_q & $past(bus_wdata)) == '0));
   // R8
   no_write_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr || hit_none) |=> $stable(en_q));
   // R4
   stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_stat) |-> (bus_rdata == (irq_src & en_q)));
   // R7
   en_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit_none) |-> (bus_rdata == en_q));
   // R8
   undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_none && !hit_stat) |-> (bus_rdata == '0));
   // R9
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
   // R5
   grp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_grp == $past(grp_now)));
endmodule

bind irq_group_combiner irqc_checker #(
   .NUM_GROUPS (NUM_GROUPS),
   .GROUP_WIDTH(GROUP_WIDTH),
   .BUS_W      (BUS_W),
   .ADDR_W     (ADDR_W),
   .OFS_SET    (OFS_SET),
   .OFS_CLR    (OFS_CLR),
   .OFS_STAT   (OFS_STAT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .irq_src  (irq_src),
   .irq_grp  (irq_grp),
   .en_q     (en_q)
);

// File: tb/irq_group_combiner_tb.sv
module irq_group_combiner_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 4;
   localparam int GW = 8;
   localparam int W  = NG * GW;

   typedef struct {
      string       req;
      logic [31:0] val;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;
   logic [W-1:0]  irq_src = '0;
   logic [NG-1:0] irq_grp;

   logic mon_rd = 1'b0;
   logic mon_out = 1'b0;
   exp_t rd_q[$];
   exp_t out_q[$];
   int   n_run = 0;
   int   n_fail = 0;
   logic [W-1:0] en_model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_group_combiner u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .irq_src  (irq_src),
      .irq_grp  (irq_grp)
   );

   // monitor: pops expected items and compares
   always @(negedge clk) begin
      if (mon_rd) begin
         exp_t e;
         n_run++;
         if (rd_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard read queue empty, got %h", bus_rdata);
         end else begin
            e = rd_q.pop_front();
            if (bus_rdata !== e.val) begin
               n_fail++;
               $display("FAIL %s rdata actual %h expected %h", e.req, bus_rdata, e.val);
            end
         end
      end
      if (mon_out) begin
         exp_t e;
         n_run++;
         if (out_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard output queue empty, got %b", irq_grp);
         end else begin
            e = out_q.pop_front();
            if (irq_grp !== e.val[NG-1:0]) begin
               n_fail++;
               $display("FAIL %s irq_grp actual %b expected %b", e.req, irq_grp, e.val[NG-1:0]);
            end
         end
      end
   end

   function automatic logic [NG-1:0] grp_of(input logic [W-1:0] p);
      logic [NG-1:0] r;
      for (int g = 0; g < NG; g++) r[g] = |p[g*GW +: GW];
      return r;
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (a == 4'h0) en_model = en_model | d;
      else if (a == 4'h4) en_model = en_model & ~d;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp_v, input string req);
      exp_t e;
      e.req = req; e.val = exp_v;
      rd_q.push_back(e);
      bus_addr = a; bus_rd = 1'b1; mon_rd = 1'b1;
      step();
      bus_rd = 1'b0; mon_rd = 1'b0;
   endtask

   task automatic idle_rd(input string req);
      exp_t e;
      e.req = req; e.val = '0;
      rd_q.push_back(e);
      bus_addr = 4'hC; bus_rd = 1'b0; mon_rd = 1'b1;
      step();
      mon_rd = 1'b0;
   endtask

   // one edge after now must reflect current sources and enables
   task automatic chk_out(input string req);
      exp_t e;
      e.req = req; e.val = 32'(grp_of(irq_src & en_model));
      step();
      out_q.push_back(e);
      mon_out = 1'b1;
      step();
      mon_out = 1'b0;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      irq_src = '1;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      rd(4'hC, 32'h0, "R1");
      rd(4'h0, 32'h0, "R1");
      chk_out("R1");

      // R2 set, R7 read back through both offsets
      wr(4'h0, 32'h0000_00A5);
      rd(4'h0, 32'h0000_00A5, "R2");
      wr(4'h0, 32'h0100_0100);
      rd(4'h0, 32'h0100_01A5, "R2");
      rd(4'h4, 32'h0100_01A5, "R7");

      // R3 clear: only ones take effect
      wr(4'h4, 32'h0000_0101);
      rd(4'h0, 32'h0100_00A4, "R3");
      rd(4'h4, en_model, "R7");

      // R4 status with different line patterns, masking of disabled lines
      irq_src = '1;
      rd(4'hC, 32'h0100_00A4, "R4");
      irq_src = 32'h0000_0084;
      rd(4'hC, 32'h0000_0084, "R4");
      irq_src = 32'h0000_0080;
      rd(4'hC, 32'h0000_0080, "R4");
      irq_src = 32'hFEFF_FF5B;
      rd(4'hC, 32'h0000_0000, "R4");
      chk_out("R4");

      // R5 group outputs under several patterns
      irq_src = 32'h0100_0004;
      chk_out("R5");
      irq_src = 32'h0100_0000;
      chk_out("R5");
      wr(4'h0, 32'h0020_4000);
      irq_src = 32'h0020_4000;
      chk_out("R5");
      irq_src = 32'h0000_4000;
      chk_out("R5");

      // R6 whole-group disable with all lines high
      wr(4'h0, 32'hFFFF_FFFF);
      irq_src = '1;
      chk_out("R6");
      wr(4'h4, 32'h00FF_0000);
      rd(4'h0, 32'hFF00_FFFF, "R6");
      chk_out("R6");
      wr(4'h4, 32'h0000_00FF);
      rd(4'hC, 32'hFF00_FF00, "R6");
      chk_out("R6");

      // R8 ignored writes and zero reads
      wr(4'h8, 32'hFFFF_FFFF);
      wr(4'hC, 32'h0000_0000);
      wr(4'h1, 32'hFFFF_FFFF);
      rd(4'h0, 32'hFF00_FF00, "R8");
      rd(4'h8, 32'h0, "R8");
      rd(4'h1, 32'h0, "R8");
      rd(4'hF, 32'h0, "R8");

      // R9 read data idle
      idle_rd("R9");

      // R3 clear everything
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'hC, 32'h0, "R3");
      chk_out("R3");

      step();
      if (rd_q.size() != 0 || out_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard leftover items actual %0d expected 0", rd_q.size() + out_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule